// File: doc/BRIEF.md
# Segment Register File with Access Keys

This block holds the sixteen segment registers that the first stage of address translation consults. A request presents an effective address, an access type and the current privilege state. The top bits of the address pick one register. One cycle later the block returns four things: the virtual segment identifier, both privilege keys, and the key that applies to the requesting privilege. It also returns the register's no-execute flag, a protection fault for instruction fetches into a no-execute segment, and the in-segment offset of the address. The instruction-side and data-side paths share one register file, and the access type tells them apart.

Software loads the registers through a write port that carries an index and a data word. A value that selects the unsupported direct-store mode is refused. The register keeps its old contents, and an error flag pulses for one cycle. A lookup reads the register contents as they stand before any write that is captured on the same clock edge.

Top module: `seg_key_file`

## Requirements
- R1: The entry is selected by effective address bits 31:28. `rspVsid` is bits 23:0 of that entry, and `rspOffset` is address bits 27:0.
- R2: `rspSupKey` reports bit 30 of the selected entry, and `rspProbKey` reports bit 29.
- R3: `rspKey` equals `rspProbKey` when the request had `reqProblem`=1, and `rspSupKey` otherwise.
- R4: `rspNoExec` reports bit 28. `rspFault` is 1 only when bit 28 is set and the access type is instruction fetch (2'b10). Data read (2'b00), data write (2'b01) and probe (2'b11) never fault.
- R5: A write whose data has bit 31 set is refused, and the entry keeps its previous value. `wrErr` is 1 in the cycle after that write and 0 after any other cycle.
- R6: An accepted write is visible to lookups that start in the following cycle. A lookup that starts in the same cycle as the write sees the old value.
- R7: `rspValid` is 1 exactly in the cycle after a cycle with `reqValid`=1.
- R8: After reset every entry reads as zero, and `rspValid` and `wrErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrIdx | input | 4 | Register index to write |
| wrData | input | 32 | Register write value |
| wrErr | output | 1 | Pulses for one cycle after a refused direct-store write |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 32 | Effective address |
| reqAccess | input | 2 | 00 data read, 01 data write, 10 instruction fetch, 11 probe |
| reqProblem | input | 1 | Requesting privilege is problem state |
| rspValid | output | 1 | Lookup result valid |
| rspVsid | output | 24 | Virtual segment identifier |
| rspOffset | output | 28 | Address offset inside the segment |
| rspSupKey | output | 1 | Supervisor key of the entry |
| rspProbKey | output | 1 | Problem key of the entry |
| rspKey | output | 1 | Key for the requesting privilege |
| rspNoExec | output | 1 | No-execute flag of the entry |
| rspFault | output | 1 | Instruction fetch into a no-execute segment |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 4 index bits and a 24-bit identifier. These values place the index at bits 31:28 and the control bits at 31 down to 28. The bench can therefore write all sixteen entries and sweep every entry after reset. It also covers a refused write, a write and a lookup of the same entry in one cycle, and every access type against no-execute and ordinary segments in both privilege states.

// File: rtl/seg_key_pkg.sv
package seg_key_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_PROBE = 2'b11
  } seg_access_e;

  typedef struct packed {
    logic commit;   // accepted register write
    logic reject;   // refused direct-store write
    logic capture;  // lookup request to register
  } seg_strobe_t;

endpackage

// File: rtl/seg_key_ctrl.sv
module seg_key_ctrl
  import seg_key_pkg::*;
#(
  parameter int SEG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [SEG_W-1:0] wrData,
  input  logic             reqValid,
  output seg_strobe_t      strobe,
  output logic             rspValid,
  output logic             wrErr
);
  localparam int DS_BIT = SEG_W - 1;

  logic directStore;
  assign directStore = wrData[DS_BIT];

  always_comb begin
    strobe.commit  = wrEn && !directStore;
    strobe.reject  = wrEn && directStore;
    strobe.capture = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      wrErr    <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      wrErr    <= strobe.reject;
    end
  end

  // R7: response follows request by one cycle
  assert_rsp_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R5: error flag exactly after a refused write
  assert_err_on_reject_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[DS_BIT]) |=> wrErr);
  assert_no_spurious_err_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrData[DS_BIT]) |=> !wrErr);

endmodule

// File: rtl/seg_key_datapath.sv
module seg_key_datapath
  import seg_key_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int SEG_W  = 32,
  parameter int VSID_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seg_strobe_t             strobe,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [SEG_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqAccess,
  input  logic                    reqProblem,
  output logic [VSID_W-1:0]       rspVsid,
  output logic [ADDR_W-IDX_W-1:0] rspOffset,
  output logic                    rspSupKey,
  output logic                    rspProbKey,
  output logic                    rspKey,
  output logic                    rspNoExec,
  output logic                    rspFault
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int OFF_W   = ADDR_W - IDX_W;
  localparam int SUP_BIT = SEG_W - 2;
  localparam int PRB_BIT = SEG_W - 3;
  localparam int NX_BIT  = SEG_W - 4;
  localparam int ENT_W   = VSID_W + 3;  // {sup, prob, nx, vsid}

  logic [ENT_W-1:0] segEntry [ENTRIES];
  logic [ENT_W-1:0] packedWr;
  logic             unusedWrBits;

  assign packedWr = {wrData[SUP_BIT], wrData[PRB_BIT], wrData[NX_BIT],
                     wrData[VSID_W-1:0]};
  assign unusedWrBits = ^{wrData[SEG_W-1], wrData[NX_BIT-1:VSID_W]};

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN)
        segEntry[e] <= '0;
      else if (strobe.commit && (wrIdx == IDX_W'(e)))
        segEntry[e] <= packedWr;
    end
  end

  logic [IDX_W-1:0] lookIdx;
  logic [ENT_W-1:0] lookEntry;
  logic             lookSup, lookPrb, lookNx;
  assign lookIdx   = reqAddr[ADDR_W-1 -: IDX_W];
  assign lookEntry = segEntry[lookIdx];
  assign lookSup   = lookEntry[ENT_W-1];
  assign lookPrb   = lookEntry[ENT_W-2];
  assign lookNx    = lookEntry[ENT_W-3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspVsid    <= '0;
      rspOffset  <= '0;
      rspSupKey  <= 1'b0;
      rspProbKey <= 1'b0;
      rspKey     <= 1'b0;
      rspNoExec  <= 1'b0;
      rspFault   <= 1'b0;
    end else if (strobe.capture) begin
      rspVsid    <= lookEntry[VSID_W-1:0];
      rspOffset  <= reqAddr[OFF_W-1:0];
      rspSupKey  <= lookSup;
      rspProbKey <= lookPrb;
      rspKey     <= reqProblem ? lookPrb : lookSup;
      rspNoExec  <= lookNx;
      rspFault   <= lookNx && (seg_access_e'(reqAccess) == ACC_FETCH);
    end
  end

  // R5: a refused write leaves the addressed entry untouched
  assert_reject_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reject |=> segEntry[$past(wrIdx)] == $past(segEntry[wrIdx]));
  // R4: a fault implies the no-execute flag and a fetch access
  assert_fault_needs_nx_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && (seg_access_e'(reqAccess) != ACC_FETCH) |=> !rspFault);
  assert_fault_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (rspFault -> rspNoExec));
  // R3: selected key tracks the requesting privilege
  assert_key_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> rspKey == ($past(reqProblem) ? rspProbKey : rspSupKey));

endmodule

// File: rtl/seg_key_file.sv
module seg_key_file
  import seg_key_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int SEG_W  = 32,
  parameter int VSID_W = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [SEG_W-1:0]        wrData,
  output logic                    wrErr,
  input  logic                    reqValid,
  input  logic [ADDR_W-1:0]       reqAddr,
  input  logic [1:0]              reqAccess,
  input  logic                    reqProblem,
  output logic                    rspValid,
  output logic [VSID_W-1:0]       rspVsid,
  output logic [ADDR_W-IDX_W-1:0] rspOffset,
  output logic                    rspSupKey,
  output logic                    rspProbKey,
  output logic                    rspKey,
  output logic                    rspNoExec,
  output logic                    rspFault
);
  seg_strobe_t strobe;

  seg_key_ctrl #(.SEG_W(SEG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .reqValid(reqValid), .strobe(strobe), .rspValid(rspValid), .wrErr(wrErr)
  );

  seg_key_datapath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEG_W(SEG_W), .VSID_W(VSID_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .wrData(wrData),
    .reqAddr(reqAddr), .reqAccess(reqAccess), .reqProblem(reqProblem),
    .rspVsid(rspVsid), .rspOffset(rspOffset), .rspSupKey(rspSupKey),
    .rspProbKey(rspProbKey), .rspKey(rspKey), .rspNoExec(rspNoExec),
    .rspFault(rspFault)
  );

endmodule

// File: tb/test_seg_key_file.sv
module test_seg_key_file;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrIdx = '0;
  logic [31:0] wrData = '0;
  logic        wrErr;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqProblem = 1'b0;
  logic        rspValid;
  logic [23:0] rspVsid;
  logic [27:0] rspOffset;
  logic        rspSupKey, rspProbKey, rspKey, rspNoExec, rspFault;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_key_file i_seg_key_file (.*);

  typedef struct packed {
    logic        valid;
    logic [23:0] vsid;
    logic [27:0] offset;
    logic        sup, prob, key, nx, fault, err;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [31:0] model [16];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus; expectation uses the model before the write
  task automatic cycle(string tag, bit we, logic [3:0] wi, logic [31:0] wd,
                       bit rv, logic [31:0] ra, logic [1:0] acc, bit prb);
    exp_t e;
    logic [31:0] ent;
    @(negedge clk);
    wrEn = we; wrIdx = wi; wrData = wd;
    reqValid = rv; reqAddr = ra; reqAccess = acc; reqProblem = prb;
    ent = model[ra[31:28]];
    e.valid  = rv;
    e.vsid   = ent[23:0];
    e.offset = ra[27:0];
    e.sup    = ent[30];
    e.prob   = ent[29];
    e.key    = prb ? ent[29] : ent[30];
    e.nx     = ent[28];
    e.fault  = ent[28] && (acc == 2'b10);
    e.err    = we && wd[31];
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (we && !wd[31]) model[wi] = {1'b0, wd[30:0]};
  endtask

  task automatic idle();
    cycle("R7", 0, 0, 0, 0, 0, 0, 0);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check("R7", "rspValid", 32'(rspValid), 32'(e.valid));
        check("R5", "wrErr", 32'(wrErr), 32'(e.err));
        if (e.valid) begin
          check({t, "/R1"}, "vsid", 32'(rspVsid), 32'(e.vsid));
          check({t, "/R1"}, "offset", 32'(rspOffset), 32'(e.offset));
          check({t, "/R2"}, "supKey", 32'(rspSupKey), 32'(e.sup));
          check({t, "/R2"}, "probKey", 32'(rspProbKey), 32'(e.prob));
          check({t, "/R3"}, "key", 32'(rspKey), 32'(e.key));
          check({t, "/R4"}, "noExec", 32'(rspNoExec), 32'(e.nx));
          check({t, "/R4"}, "fault", 32'(rspFault), 32'(e.fault));
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R8: reset state at the ports
    check("R8", "rspValid", 32'(rspValid), 0);
    check("R8", "wrErr", 32'(wrErr), 0);
    // R8: every entry reads zero, even for fetch
    for (int i = 0; i < 16; i++)
      cycle("R8", 0, 0, 0, 1, {4'(i), 28'h0ABCDEF}, 2'b10, i[0]);
    // R1/R2: load distinct patterns into all entries
    for (int i = 0; i < 16; i++)
      cycle("R1", 1, 4'(i), {1'b0, 3'(i), 4'h5, 8'(i * 37), 16'(i * 4099)},
            0, 0, 0, 0);
    // R1/R2/R3: read them back in both privilege states
    for (int i = 0; i < 16; i++) begin
      cycle("R3", 0, 0, 0, 1, {4'(15 - i), 28'(i * 1234567)}, 2'b00, 0);
      cycle("R3", 0, 0, 0, 1, {4'(15 - i), 28'(i * 7654321)}, 2'b01, 1);
    end
    // R4: every access type against no-execute and ordinary segments
    for (int a = 0; a < 4; a++) begin
      cycle("R4", 0, 0, 0, 1, 32'h1000_0004, 2'(a), 0); // entry 1: nx set
      cycle("R4", 0, 0, 0, 1, 32'h2000_0008, 2'(a), 1); // entry 2: nx clear
    end
    // R5: refused write keeps old value; then read it
    cycle("R5", 1, 4'd3, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cycle("R5", 0, 0, 0, 1, 32'h3000_0000, 2'b10, 0);
    cycle("R5", 1, 4'd9, 32'h8000_0000, 1, 32'h9123_4567, 2'b00, 1);
    idle();
    // R6: write and lookup of one entry in the same cycle, then next cycle
    cycle("R6", 1, 4'd6, 32'h7012_3456, 1, 32'h6000_0010, 2'b10, 0);
    cycle("R6", 0, 0, 0, 1, 32'h6000_0010, 2'b10, 1);
    cycle("R6", 1, 4'd6, 32'h2ABC_DEF0, 1, 32'h6FFF_FFFF, 2'b10, 0);
    cycle("R6", 0, 0, 0, 1, 32'h6FFF_FFFF, 2'b10, 1);
    // R7: gaps between requests
    idle();
    cycle("R7", 0, 0, 0, 1, 32'hF000_0001, 2'b11, 1);
    idle();
    idle();
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule